// File: doc/BRIEF.md
# Multi-Digit Decimal Adder/Subtractor

This block adds or subtracts two unsigned packed-decimal numbers of `NDIG` digits, four bits per digit with the least significant digit in bits [3:0]. It is purely combinational. A mode input picks the operation. Every digit position uses a small binary adder followed by a decimal fix-up stage. The digit cells ripple their decimal carries upward, so the width of a number is set only by the digit count.

Subtraction inverts each subtrahend digit into its nine's complement and then adds it to the minuend. If the top digit then carries out, that carry is fed back into the lowest digit by a second pass through a ripple chain, and the difference is positive. If no carry appears, the raw sum holds the nine's complement of the magnitude. The block complements it back and raises a sign output. An exact zero difference is reported with the sign clear. In add mode, the carry out of the top digit is reported on its own output. A separate flag marks any input digit above nine.

Top module: `bcd_addsub`

## Requirements
- R1: With `sub_mode`=0 and valid digits, `res_digits` equals (A + B) mod 10^NDIG in packed decimal, four bits per digit, least significant digit in bits [3:0].
- R2: `dec_carry` is 1 exactly when A + B reaches 10^NDIG in add mode, and it is always 0 when `sub_mode`=1.
- R3: `neg_flag` is always 0 when `sub_mode`=0.
- R4: With `sub_mode`=1, valid digits and A > B, `res_digits` equals A - B and `neg_flag` is 0.
- R5: With `sub_mode`=1, valid digits and A < B, `res_digits` equals the magnitude B - A and `neg_flag` is 1.
- R6: With `sub_mode`=1 and A = B (valid digits), `res_digits` is all zero and `neg_flag` is 0. The result is never all nines.
- R7: `bad_digit` is 1 exactly when any 4-bit digit of A or B is 10 to 15, in either mode. `res_digits` is then unspecified.
- R8: When `bad_digit` is 0, every 4-bit digit of `res_digits` is 9 or less.
- R9: The outputs depend only on the present inputs, with no clock and no stored state. A new operand pair takes effect without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sub_mode | input | 1 | 0 = A + B, 1 = A - B |
| opnd_a | input | 4*NDIG | Operand A (minuend), packed decimal |
| opnd_b | input | 4*NDIG | Operand B (subtrahend), packed decimal |
| res_digits | output | 4*NDIG | Sum, or magnitude of the difference |
| neg_flag | output | 1 | Difference is negative (subtract mode only) |
| dec_carry | output | 1 | Decimal carry out of the top digit (add mode only) |
| bad_digit | output | 1 | Some input digit is above nine |

## Verification
Every result of this block is due in the same cycle as its stimulus, zero clock edges later. The path runs through up to two ripple chains and a recomplement stage, with no register anywhere. The bench changes the operands and the mode on the falling edge of its clock. It samples `res_digits`, `neg_flag`, `dec_carry` and `bad_digit` one nanosecond later, well before the next rising edge, so each sample sees the settled value of that operand pair. Expected values come from plain integer arithmetic on the decoded operands, not from any digit-level model.

// File: rtl/bcd_arith_pkg.sv
// Shared types and helpers for the decimal adder/subtractor.
// Assumes digits are 4-bit packed decimal codes.
package bcd_arith_pkg;

    typedef logic [3:0] digit_t;

    localparam digit_t DIGIT_NINE = 4'd9;

    // Nine's complement of one digit: inverted digit plus 1010, carry dropped.
    function automatic digit_t nines_of(input digit_t d);
        digit_t inv;
        inv = ~d;
        return inv + 4'b1010;
    endfunction

    // True when a 4-bit code is not a decimal digit.
    function automatic logic digit_is_bad(input digit_t d);
        return d > DIGIT_NINE;
    endfunction

endpackage

// File: rtl/bcd_digit_cell.sv
// One decimal digit position: a 4-bit binary add, then the decimal fix-up.
// Assumes valid digit inputs. Codes above nine produce an unspecified digit.
module bcd_digit_cell
    import bcd_arith_pkg::*;
(
    input  digit_t x_dig,
    input  digit_t y_dig,
    input  logic   cin,
    output digit_t s_dig,
    output logic   cout
);
    logic [4:0] raw_sum;
    logic       fix_up;
    logic [4:0] adj_sum;

    // Binary sum of both digits and the incoming carry.
    always_comb raw_sum = {1'b0, x_dig} + {1'b0, y_dig} + {4'b0, cin};

    // Add six when the sum is above nine or carried past bit 3.
    always_comb begin
        fix_up  = raw_sum[4] || (raw_sum[3:0] > DIGIT_NINE);
        adj_sum = fix_up ? (raw_sum + 5'd6) : raw_sum;
    end

    assign s_dig = adj_sum[3:0];
    assign cout  = fix_up;
endmodule

// File: rtl/bcd_ripple_chain.sv
// NDIG digit cells, each one's decimal carry feeding the next digit up.
// Assumes the least significant digit sits in bits [3:0].
module bcd_ripple_chain #(
    parameter int NDIG = 4
) (
    input  logic [4*NDIG-1:0] x_word,
    input  logic [4*NDIG-1:0] y_word,
    input  logic              cin,
    output logic [4*NDIG-1:0] s_word,
    output logic              cout
);
    logic [NDIG:0] carry;

    assign carry[0] = cin;

    for (genvar g = 0; g < NDIG; g++) begin : g_cell
        bcd_digit_cell u_cell (
            .x_dig (x_word[4*g +: 4]),
            .y_dig (y_word[4*g +: 4]),
            .cin   (carry[g]),
            .s_dig (s_word[4*g +: 4]),
            .cout  (carry[g+1])
        );
    end

    assign cout = carry[NDIG];
endmodule

// File: rtl/bcd_nines_word.sv
// Turns each digit into nine minus that digit when enabled, else passes it through.
// Assumes valid digits. An invalid code yields an unspecified digit.
module bcd_nines_word
    import bcd_arith_pkg::*;
#(
    parameter int NDIG = 4
) (
    input  logic              en,
    input  logic [4*NDIG-1:0] d_in,
    output logic [4*NDIG-1:0] d_out
);
    for (genvar g = 0; g < NDIG; g++) begin : g_dig
        // Per-digit complement select.
        always_comb d_out[4*g +: 4] = en ? nines_of(d_in[4*g +: 4]) : d_in[4*g +: 4];
    end
endmodule

// File: rtl/bcd_addsub.sv
// Top: decimal add or nine's-complement subtract with end-around carry.
// Purely combinational. It assumes operands are unsigned packed decimal.
// A negative difference is returned as a magnitude with neg_flag set.
module bcd_addsub
    import bcd_arith_pkg::*;
#(
    parameter int NDIG = 4
) (
    input  logic              sub_mode,
    input  logic [4*NDIG-1:0] opnd_a,
    input  logic [4*NDIG-1:0] opnd_b,
    output logic [4*NDIG-1:0] res_digits,
    output logic              neg_flag,
    output logic              dec_carry,
    output logic              bad_digit
);
    localparam int W = 4 * NDIG;

    logic [W-1:0] b_eff;
    logic [W-1:0] sum_p1;
    logic         cy_p1;
    logic [W-1:0] sum_p2;
    logic         cy_p2;
    logic         eac;
    logic [W-1:0] recomp;
    logic         all_nines;
    logic [2*NDIG-1:0] dig_bad;

    // Complement the subtrahend in subtract mode.
    bcd_nines_word #(.NDIG(NDIG)) u_cmp_b (
        .en    (sub_mode),
        .d_in  (opnd_b),
        .d_out (b_eff)
    );

    // First pass: A plus (B or its complement).
    bcd_ripple_chain #(.NDIG(NDIG)) u_pass1 (
        .x_word (opnd_a),
        .y_word (b_eff),
        .cin    (1'b0),
        .s_word (sum_p1),
        .cout   (cy_p1)
    );

    assign eac = sub_mode & cy_p1;

    // Second pass: fold the end-around carry into the lowest digit.
    bcd_ripple_chain #(.NDIG(NDIG)) u_pass2 (
        .x_word (sum_p1),
        .y_word ({W{1'b0}}),
        .cin    (eac),
        .s_word (sum_p2),
        .cout   (cy_p2)
    );

    // Recomplement a negative raw difference back to a magnitude.
    bcd_nines_word #(.NDIG(NDIG)) u_cmp_r (
        .en    (1'b1),
        .d_in  (sum_p1),
        .d_out (recomp)
    );

    // Detect the all-nines raw sum that marks an exact zero difference.
    always_comb begin
        all_nines = 1'b1;
        for (int i = 0; i < NDIG; i++) begin
            if (sum_p1[4*i +: 4] != DIGIT_NINE) all_nines = 1'b0;
        end
    end

    // Flag any operand digit that is not a decimal code.
    for (genvar g = 0; g < NDIG; g++) begin : g_chk
        always_comb begin
            dig_bad[2*g]   = digit_is_bad(opnd_a[4*g +: 4]);
            dig_bad[2*g+1] = digit_is_bad(opnd_b[4*g +: 4]);
        end
    end

    // Select the result, sign and carry for the chosen mode.
    always_comb begin
        res_digits = sum_p1;
        neg_flag   = 1'b0;
        dec_carry  = 1'b0;
        if (!sub_mode) begin
            dec_carry = cy_p1;
        end else if (cy_p1) begin
            res_digits = sum_p2;
        end else begin
            res_digits = recomp;
            neg_flag   = ~all_nines;
        end
    end

    assign bad_digit = |dig_bad;

    logic unused_cy;
    assign unused_cy = cy_p2;
endmodule

// File: rtl/bcd_addsub_chk.sv
// Checker for bcd_addsub: port-level rules evaluated on settled values.
// Assumes it is attached through the bind statement at the end of this file.
module bcd_addsub_chk #(
    parameter int NDIG = 4
) (
    input logic              sub_mode,
    input logic [4*NDIG-1:0] opnd_a,
    input logic [4*NDIG-1:0] opnd_b,
    input logic [4*NDIG-1:0] res_digits,
    input logic              neg_flag,
    input logic              dec_carry,
    input logic              bad_digit
);
    logic out_digits_ok;

    // Scan the result for any digit above nine.
    always_comb begin
        out_digits_ok = 1'b1;
        for (int i = 0; i < NDIG; i++) begin
            if (res_digits[4*i +: 4] > 4'd9) out_digits_ok = 1'b0;
        end
    end

    // Port relations that must hold for every input combination.
    always_comb begin
        AST_SIGN_IN_ADD: assert (sub_mode || !neg_flag);                        // R3
        AST_NO_CARRY_IN_SUB: assert (!sub_mode || !dec_carry);                  // R2
        AST_DIGITS_DECIMAL: assert (bad_digit || out_digits_ok);                // R8
        AST_NO_NEG_ZERO: assert (!neg_flag || (res_digits != '0));              // R6
        AST_EQUAL_GIVES_ZERO: assert (!(sub_mode && !bad_digit && opnd_a == opnd_b)
                                      || (res_digits == '0 && !neg_flag));      // R6
    end
endmodule

bind bcd_addsub bcd_addsub_chk #(.NDIG(NDIG)) u_chk (
    .sub_mode   (sub_mode),
    .opnd_a     (opnd_a),
    .opnd_b     (opnd_b),
    .res_digits (res_digits),
    .neg_flag   (neg_flag),
    .dec_carry  (dec_carry),
    .bad_digit  (bad_digit)
);

// File: tb/bcd_addsub_bench.sv
// Directed bench for bcd_addsub: one task per scenario, integer reference.
module bcd_addsub_bench;
    localparam int NDIG = 4;
    localparam int W    = 4 * NDIG;
    localparam int LIM  = 10 ** NDIG;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sub_mode;
    logic [W-1:0] opnd_a;
    logic [W-1:0] opnd_b;
    logic [W-1:0] res_digits;
    logic         neg_flag;
    logic         dec_carry;
    logic         bad_digit;

    int n_vec = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    bcd_addsub #(.NDIG(NDIG)) u_bcd_addsub (
        .sub_mode   (sub_mode),
        .opnd_a     (opnd_a),
        .opnd_b     (opnd_b),
        .res_digits (res_digits),
        .neg_flag   (neg_flag),
        .dec_carry  (dec_carry),
        .bad_digit  (bad_digit)
    );

    function automatic logic [W-1:0] to_bcd(input int v);
        logic [W-1:0] r;
        int t;
        t = v;
        for (int i = 0; i < NDIG; i++) begin
            r[4*i +: 4] = 4'(t % 10);
            t = t / 10;
        end
        return r;
    endfunction

    function automatic logic all_decimal(input logic [W-1:0] w);
        for (int i = 0; i < NDIG; i++) if (w[4*i +: 4] > 4'd9) return 1'b0;
        return 1'b1;
    endfunction

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // Drive on the falling edge, sample 1 ns later (same cycle, no clock edge).
    task automatic apply(input logic m, input logic [W-1:0] a, input logic [W-1:0] b);
        @(negedge clk);
        sub_mode = m;
        opnd_a   = a;
        opnd_b   = b;
        #1;
    endtask

    task automatic t_reset_state();
        apply(1'b0, '0, '0);
        chk("R1 zero sum", res_digits, '0);
        chk("R2 zero carry", W'(dec_carry), '0);
        chk("R7 no bad digit", W'(bad_digit), '0);
    endtask

    task automatic t_add(input int a, input int b);
        apply(1'b0, to_bcd(a), to_bcd(b));
        chk("R1 add result", res_digits, to_bcd((a + b) % LIM));
        chk("R2 add carry", W'(dec_carry), W'((a + b) >= LIM));
        chk("R3 add sign", W'(neg_flag), '0);
        chk("R8 digits decimal", W'(all_decimal(res_digits)), W'(1));
        chk("R7 flag clear", W'(bad_digit), '0);
    endtask

    task automatic t_sub(input int a, input int b);
        apply(1'b1, to_bcd(a), to_bcd(b));
        if (a > b) begin
            chk("R4 sub magnitude", res_digits, to_bcd(a - b));
            chk("R4 sub sign", W'(neg_flag), '0);
        end else if (a < b) begin
            chk("R5 sub magnitude", res_digits, to_bcd(b - a));
            chk("R5 sub sign", W'(neg_flag), W'(1));
        end else begin
            chk("R6 zero result", res_digits, '0);
            chk("R6 zero sign", W'(neg_flag), '0);
        end
        chk("R2 sub carry", W'(dec_carry), '0);
        chk("R8 digits decimal", W'(all_decimal(res_digits)), W'(1));
    endtask

    task automatic t_bad_digit();
        logic [W-1:0] a;
        a = to_bcd(1234);
        a[7:4] = 4'hA;
        apply(1'b0, a, to_bcd(55));
        chk("R7 bad A digit", W'(bad_digit), W'(1));
        a = to_bcd(9999);
        a[W-1 -: 4] = 4'hF;
        apply(1'b1, to_bcd(1), a);
        chk("R7 bad B digit", W'(bad_digit), W'(1));
        apply(1'b1, to_bcd(9999), to_bcd(9999));
        chk("R7 flag drops", W'(bad_digit), '0);
    endtask

    // R9: result follows a new operand with no clock edge in between.
    task automatic t_no_clock();
        apply(1'b0, to_bcd(4321), to_bcd(1111));
        opnd_b = to_bcd(2222);
        #0.5;
        chk("R9 same-cycle update", res_digits, to_bcd(6543));
    endtask

    task automatic t_random(input int count);
        for (int k = 0; k < count; k++) begin
            int a;
            int b;
            a = int'($urandom % LIM);
            b = int'($urandom % LIM);
            t_add(a, b);
            t_sub(a, b);
        end
    endtask

    initial begin
        sub_mode = 1'b0;
        opnd_a   = '0;
        opnd_b   = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_add(0, 0);
        t_add(9999, 9999);
        t_add(9999, 1);
        t_add(5, 5);
        t_add(1234, 8765);
        t_sub(0, 0);
        t_sub(9999, 9999);
        t_sub(4567, 4567);
        t_sub(9999, 0);
        t_sub(0, 9999);
        t_sub(1000, 1);
        t_sub(1, 1000);
        t_sub(5000, 4999);
        t_bad_digit();
        t_no_clock();
        t_random(300);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule